// File: doc/BRIEF.md
# I/O Port 0x80 Diagnostic Display Target

This block sits on a 32-bit PCI bus as a simple target. The platform firmware writes progress bytes to I/O port 0x80 while it boots. The block takes each byte that reaches that fixed address, keeps it in an 8-bit register and shows it as two hexadecimal digits on a pair of seven-segment displays. The port is hardwired, so the block has no base address registers. I/O reads of the same port are still claimed, and they return the held byte so that the master never has to abort.

The block also answers Type 0 configuration cycles. A small read-only header gives the vendor, device and class identifiers, and every other configuration dword reads as zero. Configuration writes are accepted and have no effect. Each claimed cycle has exactly one data phase. DEVSEL# uses medium decode timing. If the master tries a burst, the block disconnects it with STOP#. The block generates even parity on every data phase in which it drives AD. It does not check the parity of incoming data.

All bus outputs come from registers. The sustained tri-state signals are given as a value together with an output enable, so that the pad logic around the block can build the bus drivers.

Top module: `postcode_target`

## Requirements
- R1: After a synchronous reset, devsel_n, trdy_n and stop_n are 1, ctl_oe, ad_oe and par_oe are 0, and the held byte is 0x00, so both digits show the pattern for 0.
- R2: A cycle is claimed when FRAME# is first sampled low while IRDY# is high, after a clock with both high, with cbe_n[3:1] = 3'b001 and ad_in = 32'h0000_0080. cbe_n[0] only selects read (0) or write (1). Any other address, or any non-I/O command, leaves devsel_n high.
- R3: Call the address-phase edge edge 0. devsel_n and trdy_n are still high at edge 1 and are first sampled low at edge 2 (medium decode).
- R4: The data phase completes at the first edge where irdy_n and trdy_n are both low. On an I/O write, ad_in[7:0] is stored at that edge only if cbe_n[0] is low then. Otherwise the held byte stays unchanged.
- R5: On an I/O read, ad_out = {24'h0, held byte} with ad_oe high, from the clock after edge 1 through the completion edge.
- R6: A configuration cycle needs idsel high, cbe_n = 4'b1010 (read) or 4'b1011 (write), and ad_in[1:0] = 2'b00. Dword index ad_in[7:2] = 0 reads {DEVICE_ID, VENDOR_ID}, index 2 reads {CLASS_CODE, 8'h00}, and every other index (including 4 to 9) reads 0. Configuration writes are claimed and change nothing.
- R7: par_oe is high in each clock that follows a clock with ad_oe high. In that clock, par_out makes the XOR of the previous clock's AD[31:0], C/BE#[3:0] and par_out equal to zero.
- R8: During the data phase, stop_n is low in each clock that follows an edge at which frame_n was sampled low. Together with trdy_n low, this disconnects an attempted burst after one data phase. A single-phase cycle keeps stop_n high.
- R9: At the completion edge, devsel_n, trdy_n and stop_n go high and ad_oe goes low. ctl_oe stays high for one more clock and then drops.
- R10: seg_out[13:7] shows the upper nibble and seg_out[6:0] the lower nibble, active high, with bit 0 = segment a and bit 6 = segment g. The patterns for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. The displays update one clock after the held byte does.
- R11: A configuration command with idsel low, or with ad_in[1:0] not 2'b00, is not claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | C/BE# lines |
| ad_in | input | 32 | AD lines as received |
| ad_out | output | 32 | AD value to drive on reads |
| ad_oe | output | 1 | Drive enable for AD |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | Drive enable for PAR |
| devsel_n | output | 1 | DEVSEL# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| ctl_oe | output | 1 | Drive enable for DEVSEL#, TRDY# and STOP# |
| seg_out | output | 14 | Two seven-segment digit patterns, upper digit in the high bits |

## Verification
Two functions can fall on the same edge: the data phase completing (TRDY# with IRDY#) and the disconnect (STOP#). The bench provokes this by holding FRAME# low through the completion edge on writes. At that edge it expects STOP# and TRDY# both low, and it still expects the byte to be captured and displayed. The parity drive also overlaps the bus release. In the clock where AD, DEVSEL# and TRDY# are let go, PAR must still be driven, and the bench checks it against parity computed from the read data and byte enables it observed one clock earlier.

// File: rtl/postcode_pkg.sv
package postcode_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_IO_RD, K_IO_WR, K_CFG_RD, K_CFG_WR
  } claim_e;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_DATA, S_TURN
  } tstate_e;

  localparam logic [2:0] CMD_IO_UPPER = 3'b001;
  localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
endpackage

// File: rtl/postcode_addr_decode.sv
module postcode_addr_decode
  import postcode_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int CBE_W = AD_W / 8,
  parameter logic [AD_W-1:0] PORT_ADDR = 32'h0000_0080,
  parameter int IDX_W = 6
) (
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic             idsel,
  output claim_e           kind,
  output logic [IDX_W-1:0] cfg_idx
);
  always_comb begin
    kind = K_NONE;
    if (cbe_n[3:1] == CMD_IO_UPPER && ad == PORT_ADDR) begin
      kind = cbe_n[0] ? K_IO_WR : K_IO_RD;
    end else if (idsel && ad[1:0] == 2'b00) begin
      if (cbe_n == CMD_CFG_RD)      kind = K_CFG_RD;
      else if (cbe_n == CMD_CFG_WR) kind = K_CFG_WR;
    end
  end

  assign cfg_idx = ad[IDX_W+1:2];
endmodule

// File: rtl/postcode_cfg_rom.sv
module postcode_cfg_rom #(
  parameter int AD_W = 32,
  parameter int IDX_W = 6,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID = 16'h0080,
  parameter logic [23:0] CLASS_CODE = 24'hFF0000
) (
  input  logic [IDX_W-1:0] idx,
  output logic [AD_W-1:0]  dword
);
  always_comb begin
    case (idx)
      IDX_W'(0): dword = AD_W'({DEVICE_ID, VENDOR_ID});
      IDX_W'(2): dword = AD_W'({CLASS_CODE, 8'h00});
      default:   dword = '0;
    endcase
  end
endmodule

// File: rtl/postcode_hex7.sv
module postcode_hex7 (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] nib,
  output logic [6:0] seg
);
  always_ff @(posedge clk) begin
    if (rst) seg <= 7'h3F;
    else begin
      case (nib)
        4'h0: seg <= 7'h3F;
        4'h1: seg <= 7'h06;
        4'h2: seg <= 7'h5B;
        4'h3: seg <= 7'h4F;
        4'h4: seg <= 7'h66;
        4'h5: seg <= 7'h6D;
        4'h6: seg <= 7'h7D;
        4'h7: seg <= 7'h07;
        4'h8: seg <= 7'h7F;
        4'h9: seg <= 7'h6F;
        4'hA: seg <= 7'h77;
        4'hB: seg <= 7'h7C;
        4'hC: seg <= 7'h39;
        4'hD: seg <= 7'h5E;
        4'hE: seg <= 7'h79;
        default: seg <= 7'h71;
      endcase
    end
  end

  // R10
  seg_lit_chk: assert property (@(posedge clk) disable iff (rst) seg != 7'h00);
endmodule

// File: rtl/postcode_tgt_fsm.sv
module postcode_tgt_fsm
  import postcode_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int CBE_W = AD_W / 8,
  parameter int IDX_W = 6,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic [CODE_W-1:0] wr_byte,
  input  claim_e            kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [AD_W-1:0]   cfg_dword,
  output logic [IDX_W-1:0]  idx_q,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              par_out,
  output logic              par_oe,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              ctl_oe,
  output logic [CODE_W-1:0] code
);
  tstate_e st;
  claim_e  kind_q;
  logic    bus_idle_q;
  logic    addr_phase;

  assign addr_phase = !frame_n && irdy_n && bus_idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind_q     <= K_NONE;
      idx_q      <= '0;
      devsel_n   <= 1'b1;
      trdy_n     <= 1'b1;
      stop_n     <= 1'b1;
      ctl_oe     <= 1'b0;
      ad_oe      <= 1'b0;
      ad_out     <= '0;
      par_out    <= 1'b0;
      par_oe     <= 1'b0;
      code       <= '0;
      bus_idle_q <= 1'b1;
    end else begin
      bus_idle_q <= frame_n && irdy_n;
      par_out    <= ^{ad_out, cbe_n};
      par_oe     <= ad_oe;
      case (st)
        S_IDLE: begin
          if (addr_phase && kind != K_NONE) begin
            st     <= S_WAIT;
            kind_q <= kind;
            idx_q  <= cfg_idx;
          end
        end
        S_WAIT: begin
          st       <= S_DATA;
          devsel_n <= 1'b0;
          trdy_n   <= 1'b0;
          ctl_oe   <= 1'b1;
          stop_n   <= frame_n;
          if (kind_q == K_IO_RD) begin
            ad_oe  <= 1'b1;
            ad_out <= AD_W'(code);
          end else if (kind_q == K_CFG_RD) begin
            ad_oe  <= 1'b1;
            ad_out <= cfg_dword;
          end
        end
        S_DATA: begin
          if (!irdy_n) begin
            st       <= S_TURN;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
            if (kind_q == K_IO_WR && !cbe_n[0]) code <= wr_byte;
          end else begin
            stop_n <= frame_n;
          end
        end
        default: begin
          ctl_oe <= 1'b0;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  // R3
  medium_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && addr_phase && kind != K_NONE) |=> devsel_n ##1 !devsel_n);
  // R8
  stop_with_trdy_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !trdy_n);
  // R5
  ad_drive_claimed_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!devsel_n && ctl_oe));
  // R9
  turn_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_n) |-> (!ad_oe && ctl_oe && trdy_n && stop_n));
  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(st == S_DATA && !irdy_n && kind_q == K_IO_WR && !cbe_n[0]) |=> $stable(code));
  // R7
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe) |-> par_oe);
endmodule

// File: rtl/postcode_target.sv
module postcode_target
  import postcode_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int CODE_W = 8,
  parameter logic [AD_W-1:0] PORT_ADDR = 32'h0000_0080,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID = 16'h0080,
  parameter logic [23:0] CLASS_CODE = 24'hFF0000,
  localparam int CBE_W = AD_W / 8,
  localparam int IDX_W = 6,
  localparam int DIGITS = CODE_W / 4,
  localparam int SEG_W = 7 * DIGITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             idsel,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic [AD_W-1:0]  ad_in,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic             par_out,
  output logic             par_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic [SEG_W-1:0] seg_out
);
  claim_e            kind;
  logic [IDX_W-1:0]  cfg_idx;
  logic [IDX_W-1:0]  idx_q;
  logic [AD_W-1:0]   cfg_dword;
  logic [CODE_W-1:0] code;

  postcode_addr_decode #(
    .AD_W(AD_W), .CBE_W(CBE_W), .PORT_ADDR(PORT_ADDR), .IDX_W(IDX_W)
  ) u_dec (
    .ad(ad_in), .cbe_n(cbe_n), .idsel(idsel), .kind(kind), .cfg_idx(cfg_idx)
  );

  postcode_cfg_rom #(
    .AD_W(AD_W), .IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE)
  ) u_rom (
    .idx(idx_q), .dword(cfg_dword)
  );

  postcode_tgt_fsm #(
    .AD_W(AD_W), .CBE_W(CBE_W), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .wr_byte(ad_in[CODE_W-1:0]), .kind(kind),
    .cfg_idx(cfg_idx), .cfg_dword(cfg_dword), .idx_q(idx_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ctl_oe(ctl_oe), .code(code)
  );

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    postcode_hex7 u_hex (
      .clk(clk), .rst(rst), .nib(code[4*g +: 4]), .seg(seg_out[7*g +: 7])
    );
  end
endmodule

// File: tb/sim_postcode_target.sv
module sim_postcode_target;
  localparam logic [15:0] VID = 16'h1D0F;
  localparam logic [15:0] DID = 16'h0080;
  localparam logic [23:0] CCODE = 24'hFF0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, ctl_oe;
  logic [13:0] seg_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  postcode_target #(.VENDOR_ID(VID), .DEVICE_ID(DID), .CLASS_CODE(CCODE)) u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .ctl_oe(ctl_oe), .seg_out(seg_out)
  );

  function automatic logic [6:0] sev(input logic [3:0] d);
    case (d)
      4'h0: sev = 7'h3F; 4'h1: sev = 7'h06; 4'h2: sev = 7'h5B; 4'h3: sev = 7'h4F;
      4'h4: sev = 7'h66; 4'h5: sev = 7'h6D; 4'h6: sev = 7'h7D; 4'h7: sev = 7'h07;
      4'h8: sev = 7'h7F; 4'h9: sev = 7'h6F; 4'hA: sev = 7'h77; 4'hB: sev = 7'h7C;
      4'hC: sev = 7'h39; 4'hD: sev = 7'h5E; 4'hE: sev = 7'h79; default: sev = 7'h71;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus transaction of one data phase, with timing and release checks.
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                     input logic [3:0] be, input logic [31:0] wd, input logic burst,
                     output logic claimed, output logic [31:0] rd);
    logic is_rd;
    is_rd = (cmd[0] == 1'b0);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    chk("R3 devsel not fast", {31'b0, devsel_n}, 32'd1);
    frame_n = !burst; irdy_n = 1'b0; cbe_n = be; idsel = 1'b0;
    ad_in = is_rd ? 32'h0 : wd;
    @(negedge clk);
    claimed = !devsel_n;
    rd = ad_out;
    if (claimed) begin
      chk("R3 trdy with devsel", {31'b0, trdy_n}, 32'd0);
      chk("R8 stop level", {31'b0, stop_n}, {31'b0, !burst});
      chk("R5 ad drive", {31'b0, ad_oe}, {31'b0, is_rd});
      @(negedge clk);
      chk("R9 released", {27'b0, devsel_n, trdy_n, stop_n, ad_oe, ctl_oe}, 32'b11101);
      chk("R7 par enable", {31'b0, par_oe}, {31'b0, is_rd});
      if (is_rd) chk("R7 even parity", {31'b0, par_out ^ (^rd) ^ (^be)}, 32'd0);
      frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
      @(negedge clk);
      chk("R9 ctl release", {30'b0, ctl_oe, par_oe}, 32'd0);
    end else begin
      frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
      @(negedge clk);
    end
  endtask

  task automatic read_code(input logic [7:0] exp, input string tag);
    logic c;
    logic [31:0] r;
    txn(4'b0010, 32'h80, 1'b0, 4'h0, 32'h0, 1'b0, c, r);
    chk({tag, " read claimed"}, {31'b0, c}, 32'd1);
    chk({tag, " read value"}, r, {24'h0, exp});
    chk({tag, " display"}, {18'b0, seg_out}, {18'b0, sev(exp[7:4]), sev(exp[3:0])});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic c;
    logic [31:0] r;
    logic [31:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 handshake idle", {29'b0, devsel_n, trdy_n, stop_n}, 32'b111);
    chk("R1 enables low", {29'b0, ctl_oe, ad_oe, par_oe}, 32'b0);
    chk("R1 display zero", {18'b0, seg_out}, {18'b0, 7'h3F, 7'h3F});

    // R2 R4 R5 R10: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      txn(4'b0011, 32'h80, 1'b0, {v[2:0], 1'b0}, {~b, b ^ 8'h5A, 8'hC3, b}, 1'b0, c, r);
      chk("R2 write claimed", {31'b0, c}, 32'd1);
      chk("R10 display after write", {18'b0, seg_out}, {18'b0, sev(b[7:4]), sev(b[3:0])});
      read_code(b, "R5");
    end

    // R4: lane 0 disabled leaves the byte
    txn(4'b0011, 32'h80, 1'b0, 4'b0001, 32'h0000_0055, 1'b0, c, r);
    chk("R4 lane0 off claimed", {31'b0, c}, 32'd1);
    read_code(8'hFF, "R4 lane0 off");

    // R2: near misses not claimed
    txn(4'b0011, 32'h84, 1'b0, 4'h0, 32'h11, 1'b0, c, r);
    chk("R2 addr 0x84", {31'b0, c}, 32'd0);
    txn(4'b0011, 32'h81, 1'b0, 4'h0, 32'h22, 1'b0, c, r);
    chk("R2 addr 0x81", {31'b0, c}, 32'd0);
    txn(4'b0011, 32'h180, 1'b0, 4'h0, 32'h33, 1'b0, c, r);
    chk("R2 addr 0x180", {31'b0, c}, 32'd0);
    txn(4'b0111, 32'h80, 1'b0, 4'h0, 32'h44, 1'b0, c, r);
    chk("R2 memory write", {31'b0, c}, 32'd0);
    read_code(8'hFF, "R2 misses");

    // R6: configuration header reads
    for (int i = 0; i < 16; i++) begin
      txn(4'b1010, i << 2, 1'b1, 4'h0, 32'h0, 1'b0, c, r);
      chk("R6 cfg claimed", {31'b0, c}, 32'd1);
      exp = (i == 0) ? {DID, VID} : (i == 2) ? {CCODE, 8'h00} : 32'h0;
      chk("R6 cfg dword", r, exp);
    end

    // R11: configuration misses
    txn(4'b1010, 32'h0, 1'b0, 4'h0, 32'h0, 1'b0, c, r);
    chk("R11 idsel low", {31'b0, c}, 32'd0);
    txn(4'b1010, 32'h1, 1'b1, 4'h0, 32'h0, 1'b0, c, r);
    chk("R11 ad low bits", {31'b0, c}, 32'd0);

    // R6: configuration write has no effect
    txn(4'b1011, 32'h0, 1'b1, 4'h0, 32'hDEAD_BEEF, 1'b0, c, r);
    chk("R6 cfg write claimed", {31'b0, c}, 32'd1);
    txn(4'b1010, 32'h0, 1'b1, 4'h0, 32'h0, 1'b0, c, r);
    chk("R6 cfg after write", r, {DID, VID});
    read_code(8'hFF, "R6 cfg write");

    // R8: burst attempt, disconnect and capture on the same edge
    txn(4'b0011, 32'h80, 1'b0, 4'h0, 32'h0000_00A5, 1'b1, c, r);
    chk("R8 burst claimed", {31'b0, c}, 32'd1);
    read_code(8'hA5, "R8 burst");
    txn(4'b0010, 32'h80, 1'b0, 4'h0, 32'h0, 1'b1, c, r);
    chk("R8 burst read", r, 32'h0000_00A5);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule